// File: doc/BRIEF.md
# Power Fault Sleep Sequencer

This block decides when a small system-on-chip goes to sleep, when it may wake up, and when its reset output is held. It runs from a slow always-on clock. A battery fault or a supply fault seen while running sends the system to sleep, and sleep entry drops the external supply enable. A wake-up event brings the supply enable back and opens a settling window of a fixed length. The system returns to run once that window ends.

Wake-up is refused for as long as the battery fault is present. During the settling window the supply fault is ignored, because the supply may still be out of regulation at that point. A battery fault seen during the window sends the system back toward sleep.

The reset output is held low for several causes: hard reset, any state other than run, and a watchdog request. After the last cause clears, it stays low for a programmable number of extra cycles. The hard reset input is also the block's own asynchronous reset. All other inputs are asynchronous and are passed through two-flop synchronizers.

Top module: `pfs_sleep_seq`

## Requirements
- R1: While rst_ni is low, state_o reads RESET (code 0), rst_out_no is 0 and pwr_en_o is 1. State codes are: RESET=0, RUN=1, SLEEP_ENTRY=2, SLEEP=3, WAKE_SETTLE=4.
- R2: After rst_ni rises, the state moves from RESET to RUN on the next clock edge. rst_out_no then stays 0 for exactly STRETCH_CYCLES sampled cycles of RUN before it goes to 1.
- R3: A battery fault asserted in RUN moves the state to SLEEP_ENTRY on the third clock edge after the input change (two edges in the synchronizer, one in the state register). SLEEP_ENTRY always lasts exactly one cycle and is followed by SLEEP.
- R4: A supply fault asserted in RUN moves the state to SLEEP_ENTRY with the same three-edge latency.
- R5: pwr_en_o is 1 in RESET, RUN and WAKE_SETTLE, and 0 in SLEEP_ENTRY and SLEEP.
- R6: In SLEEP, a synchronized wake-up event with no battery fault present moves the state to WAKE_SETTLE. While the battery fault is asserted, a wake-up event leaves the state in SLEEP.
- R7: WAKE_SETTLE lasts exactly SETTLE_CYCLES cycles and then moves to RUN. A supply fault has no effect during this window. A supply fault still present on RUN entry sends the state to SLEEP_ENTRY.
- R8: A battery fault during WAKE_SETTLE moves the state to SLEEP_ENTRY.
- R9: rst_out_no is 0 in every state other than RUN. After each entry into RUN it stays 0 for STRETCH_CYCLES cycles.
- R10: A watchdog request in RUN holds rst_out_no at 0 without changing the state. After the request is removed, rst_out_no stays 0 for STRETCH_CYCLES+1 sampled cycles, which includes the synchronizer delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on slow clock |
| rst_ni | input | 1 | Hard reset, active low, asynchronous, level-sensitive |
| batt_fault_i | input | 1 | Battery fault, active high, asynchronous |
| vdd_fault_i | input | 1 | Supply fault, active high, asynchronous |
| wake_i | input | 1 | Wake-up event, active high, asynchronous |
| wdt_rst_i | input | 1 | Watchdog reset request, active high, asynchronous |
| pwr_en_o | output | 1 | External supply enable, active high |
| rst_out_no | output | 1 | Reset output, active low |
| state_o | output | 3 | Current state code |

## Verification
The hardest situation to reach from the ports is a supply fault that arrives inside the settling window and is still present when the window closes. The stimulus raises the supply fault right after WAKE_SETTLE is observed. It then counts the window length, expects no effect during the window, and expects sleep entry right after RUN. A second hard case is a battery fault that stays asserted while wake pulses arrive. The bench holds the fault through several wake pulses and checks that the block stays in SLEEP. A scoreboard queue holds every state transition the driver expects, so any extra or missing transition shows up as a miscompare.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  typedef enum logic [2:0] {
    ST_RESET       = 3'd0,
    ST_RUN         = 3'd1,
    ST_SLEEP_ENTRY = 3'd2,
    ST_SLEEP       = 3'd3,
    ST_WAKE_SETTLE = 3'd4
  } pfs_state_e;
endpackage

// File: rtl/pfs_sync.sv
module pfs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/pfs_settle_timer.sv
module pfs_settle_timer #(
  parameter int CYCLES = 328
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic run_i,
  output logic done_o
);
  localparam int W = (CYCLES > 2) ? $clog2(CYCLES) : 1;
  localparam logic [W-1:0] LOAD = W'(CYCLES - 1);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (start_i)                  cnt_q <= LOAD;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = run_i && (cnt_q == '0);

  // a fresh load never reports done in the following cycle
  AST_TMR_NO_EARLY_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && CYCLES > 1) |=> !done_o); // R7
endmodule

// File: rtl/pfs_rst_stretch.sv
module pfs_rst_stretch #(
  parameter int STRETCH = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cause_i,
  output logic rst_no
);
  localparam int W = $clog2(STRETCH + 1);
  localparam logic [W-1:0] LOAD = W'(STRETCH);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= LOAD;
    else if (cause_i)         cnt_q <= LOAD;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign rst_no = rst_ni && !cause_i && (cnt_q == '0);

  AST_STRETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cause_i && STRETCH > 0) |=> !rst_no); // R9
endmodule

// File: rtl/pfs_sleep_seq.sv
module pfs_sleep_seq
  import pfs_pkg::*;
#(
  parameter int SETTLE_CYCLES  = 328,
  parameter int STRETCH_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       batt_fault_i,
  input  logic       vdd_fault_i,
  input  logic       wake_i,
  input  logic       wdt_rst_i,
  output logic       pwr_en_o,
  output logic       rst_out_no,
  output logic [2:0] state_o
);
  localparam int NSYNC = 4;

  logic [NSYNC-1:0] raw_in, sync_in;
  logic batt_s, vdd_s, wake_s, wdt_s;

  assign raw_in = {wdt_rst_i, wake_i, vdd_fault_i, batt_fault_i};

  pfs_sync #(.WIDTH(NSYNC)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (sync_in)
  );

  assign {wdt_s, wake_s, vdd_s, batt_s} = sync_in;

  pfs_state_e state_q, state_d;
  logic settle_start, settle_done, settle_run;

  assign settle_run   = (state_q == ST_WAKE_SETTLE);
  assign settle_start = (state_q == ST_SLEEP) && wake_s && !batt_s;

  pfs_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(settle_start),
    .run_i  (settle_run),
    .done_o (settle_done)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_RESET:       state_d = ST_RUN;
      ST_RUN:         if (batt_s || vdd_s) state_d = ST_SLEEP_ENTRY;
      ST_SLEEP_ENTRY: state_d = ST_SLEEP;
      ST_SLEEP:       if (settle_start) state_d = ST_WAKE_SETTLE;
      ST_WAKE_SETTLE: begin
        // supply fault is masked here
        if (batt_s)           state_d = ST_SLEEP_ENTRY;
        else if (settle_done) state_d = ST_RUN;
      end
      default:        state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RESET;
    else         state_q <= state_d;
  end

  logic rst_cause;
  assign rst_cause = (state_q != ST_RUN) || wdt_s;

  pfs_rst_stretch #(.STRETCH(STRETCH_CYCLES)) u_stretch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cause_i(rst_cause),
    .rst_no (rst_out_no)
  );

  always_comb begin
    unique case (state_q)
      ST_SLEEP_ENTRY, ST_SLEEP: pwr_en_o = 1'b0;
      default:                  pwr_en_o = 1'b1;
    endcase
  end

  assign state_o = state_q;

  AST_FAULT_TO_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && (batt_s || vdd_s)) |=> (state_q == ST_SLEEP_ENTRY)); // R4
  AST_ENTRY_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP_ENTRY) |=> (state_q == ST_SLEEP)); // R3
  AST_WAKE_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && batt_s) |=> (state_q == ST_SLEEP)); // R6
  AST_SETTLE_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE_SETTLE && !batt_s) |=>
      (state_q == ST_WAKE_SETTLE || state_q == ST_RUN)); // R7
  AST_SETTLE_BATT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE_SETTLE && batt_s) |=> (state_q == ST_SLEEP_ENTRY)); // R8
  AST_RST_OFF_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_RUN) |-> !rst_out_no); // R9
  AST_PWR_OFF_ASLEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP) |-> !pwr_en_o); // R5
  AST_RESET_TO_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESET) |=> (state_q == ST_RUN)); // R2
endmodule

// File: tb/pfs_sleep_seq_bench.sv
module pfs_sleep_seq_bench;
  localparam int SETTLE  = 328;
  localparam int STRETCH = 8;
  localparam logic [2:0] S_RESET = 3'd0, S_RUN = 3'd1, S_SE = 3'd2,
                         S_SLEEP = 3'd3, S_WS = 3'd4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic batt = 1'b0, vdd = 1'b0, wake = 1'b0, wdt = 1'b0;
  logic pwr_en, rst_out_n;
  logic [2:0] state;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic [2:0] exp_q[$];
  logic [2:0] prev_state = S_RESET;

  always #2 clk = ~clk;

  pfs_sleep_seq #(.SETTLE_CYCLES(SETTLE), .STRETCH_CYCLES(STRETCH)) u_pfs_sleep_seq (
    .clk_i(clk), .rst_ni(rst_ni), .batt_fault_i(batt), .vdd_fault_i(vdd),
    .wake_i(wake), .wdt_rst_i(wdt), .pwr_en_o(pwr_en), .rst_out_no(rst_out_n),
    .state_o(state)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_state(input logic [2:0] s);
    int guard = 0;
    while (state != s && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // scoreboard monitor: every state change must match the queue head
  always @(negedge clk) begin
    if (rst_ni && state != prev_state) begin
      n_chk++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL R3: unexpected transition actual %0d expected none", state);
      end else begin
        logic [2:0] e;
        e = exp_q.pop_front();
        if (state != e) begin
          n_fail++;
          $display("FAIL R6: transition actual %0d expected %0d", state, e);
        end
      end
    end
    prev_state = state;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    cyc(3);
    // R1 reset state
    check("R1 state", state, S_RESET);
    check("R1 rst_out", rst_out_n, 0);
    check("R1 pwr_en", pwr_en, 1);

    // R2 release and stretch
    exp_q.push_back(S_RUN);
    rst_ni = 1'b1;
    wait_state(S_RUN);
    n = 0;
    while (!rst_out_n && n < 100) begin n++; @(negedge clk); end
    check("R2 stretch after reset", n, STRETCH);

    // R10 watchdog
    wdt = 1'b1;
    cyc(1);
    check("R10 wdt not yet synced", rst_out_n, 1);
    cyc(1);
    check("R10 wdt asserts reset", rst_out_n, 0);
    cyc(3);
    wdt = 1'b0;
    n = 0;
    @(negedge clk);
    while (!rst_out_n && n < 100) begin n++; @(negedge clk); end
    check("R10 wdt stretch", n, STRETCH + 1);
    check("R10 state stays run", state, S_RUN);

    // R3 battery fault from run
    exp_q.push_back(S_SE); exp_q.push_back(S_SLEEP);
    batt = 1'b1;
    cyc(2);
    check("R3 latency not yet", state, S_RUN);
    cyc(1);
    check("R3 entry", state, S_SE);
    check("R5 pwr off in entry", pwr_en, 0);
    check("R9 rst low in entry", rst_out_n, 0);
    cyc(1);
    check("R3 sleep", state, S_SLEEP);

    // R6 wake blocked by battery fault
    repeat (3) begin wake = 1'b1; cyc(4); wake = 1'b0; cyc(4); end
    check("R6 blocked wake", state, S_SLEEP);
    check("R5 pwr off asleep", pwr_en, 0);
    batt = 1'b0;
    cyc(4);

    // R7 settle window with supply fault inside it
    exp_q.push_back(S_WS); exp_q.push_back(S_RUN);
    exp_q.push_back(S_SE); exp_q.push_back(S_SLEEP);
    wake = 1'b1;
    wait_state(S_WS);
    wake = 1'b0;
    vdd = 1'b1;
    check("R5 pwr on in settle", pwr_en, 1);
    n = 0;
    while (state == S_WS && n < 5000) begin n++; @(negedge clk); end
    check("R7 settle length", n, SETTLE);
    check("R7 run after settle", state, S_RUN);
    cyc(1);
    check("R7 late supply fault", state, S_SE);
    cyc(1);
    vdd = 1'b0;
    cyc(4);

    // R8 battery fault during settle
    exp_q.push_back(S_WS); exp_q.push_back(S_SE); exp_q.push_back(S_SLEEP);
    wake = 1'b1;
    wait_state(S_WS);
    wake = 1'b0;
    cyc(20);
    batt = 1'b1;
    cyc(3);
    check("R8 abort settle", state, S_SE);
    cyc(2);
    batt = 1'b0;
    cyc(4);

    // R9 stretch after wake returns to run
    exp_q.push_back(S_WS); exp_q.push_back(S_RUN);
    wake = 1'b1;
    wait_state(S_WS);
    wake = 1'b0;
    check("R9 rst low in settle", rst_out_n, 0);
    wait_state(S_RUN);
    n = 0;
    while (!rst_out_n && n < 100) begin n++; @(negedge clk); end
    check("R9 stretch after wake", n, STRETCH);

    // R4 supply fault from run
    exp_q.push_back(S_SE); exp_q.push_back(S_SLEEP);
    vdd = 1'b1;
    cyc(2);
    check("R4 latency not yet", state, S_RUN);
    cyc(1);
    check("R4 entry", state, S_SE);
    cyc(2);
    vdd = 1'b0;

    // R1 hard reset from sleep
    rst_ni = 1'b0;
    cyc(2);
    check("R1 state in reset", state, S_RESET);
    check("R1 rst_out in reset", rst_out_n, 0);
    check("R1 pwr_en in reset", pwr_en, 1);
    exp_q.push_back(S_RUN);
    rst_ni = 1'b1;
    cyc(3);
    check("R2 run after release", state, S_RUN);
    check("R2 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule